// File: doc/BRIEF.md
# Eighth-Order Fixed-Point IIR Bandpass Filter

This block computes one output of an eighth-order recursive filter for each signed input sample it accepts. The output is the sum of a fixed numerator and a programmable denominator. The numerator is the binomial expansion of (1 - z^-2)^4. Its odd taps are zero, so only the five even-delay input terms are formed, and they are built from shifts and adds alone. The denominator has eight fractional coefficients, held in a small register bank, and one sequential multiply-accumulate unit applies them to the past outputs, one tap per cycle.

The coefficients are signed fixed-point numbers with 8 integer bits and 24 fraction bits, written through an address/data/write-enable port. The outputs and the output history are 32-bit signed integers. Each product is rounded before it is accumulated. The final sum is clipped to the 32-bit range before it is presented and before it is stored as history. A full result needs nine cycles, which is far shorter than the sample period of an audio-rate bandpass.

Top module: `iir_bandpass8`

## Requirements
- R1: With all feedback coefficients zero, the output is x[n] - 4*x[n-2] + 6*x[n-4] - 4*x[n-6] + x[n-8]. All input history is zero after reset.
- R2: The output is that feed-forward sum minus the sum of a_k * y[n-k] for k = 1..8. Here a_k is a signed value with 24 fraction bits (1.0 = 0x01000000), written to address k-1 on coef_addr when coef_we is high at a clock edge.
- R3: Each product a_k * y[n-k] is rounded to the nearest integer before it is subtracted, and a tie rounds toward positive infinity (+1.5 gives 2, -5.5 gives -5).
- R4: The result is clipped to the range [-2147483648, 2147483647], and the clipped value is what enters the output history.
- R5: out_valid is high for exactly one cycle. It is seen high 9 clock edges after the edge that accepts in_valid.
- R6: in_valid is ignored while a result is being computed: the sample offered then enters neither the current output nor the history.
- R7: y_out holds its value between out_valid pulses.
- R8: A synchronous reset clears both histories and all coefficients, and drives out_valid and y_out to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | New sample offered |
| in_sample | input | IN_W | Signed input sample |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | $clog2(ORDER) | Coefficient index, k-1 for a_k |
| coef_data | input | COEF_W | Signed coefficient, FRAC_W fraction bits |
| out_valid | output | 1 | One-cycle result strobe |
| y_out | output | OUT_W | Signed filtered output |

## Verification
The bench builds the block with its default values: 16-bit samples, 32-bit coefficients with 24 fraction bits, 8 feedback taps, a fourth-order binomial numerator and round-to-nearest products. With 8 integer coefficient bits, a single tap of -128.0 drives the output into both clip limits within a few samples. A coefficient of exactly 0.5 turns odd outputs into rounding ties of either sign, which separates round-to-nearest from truncation. Zero coefficients expose the bare numerator impulse response. Two-tap programs are compared against an arithmetic model written from the requirements.

// File: rtl/iirbp_pkg.sv
package iirbp_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_MAC  = 2'd1,
      ST_DONE = 2'd2
   } seq_state_t;

   // n choose k, used to build the numerator taps at elaboration
   function automatic int unsigned binom(input int unsigned n, input int unsigned k);
      int unsigned r;
      r = 1;
      for (int unsigned i = 0; i < k; i++) begin
         r = r * (n - i) / (i + 1);
      end
      return r;
   endfunction

endpackage

// File: rtl/iirbp_ff_path.sv
module iirbp_ff_path #(
   parameter int IN_W     = 16,
   parameter int FF_ORDER = 4,
   parameter int FFW      = IN_W + FF_ORDER + 1
) (
   input  logic signed [IN_W-1:0] x_even [FF_ORDER+1],
   output logic signed [FFW-1:0]  ff_sum
);
   localparam int MAGW = FF_ORDER + 1;

   logic signed [FFW-1:0] chain [FF_ORDER+2];
   assign chain[0] = '0;

   for (genvar m = 0; m <= FF_ORDER; m++) begin : g_tap
      localparam int unsigned MAG = iirbp_pkg::binom(FF_ORDER, m);
      localparam bit          NEG = (m % 2) == 1;

      logic signed [FFW-1:0] xe;
      logic signed [FFW-1:0] part [MAGW+1];

      assign xe      = {{(FFW-IN_W){x_even[m][IN_W-1]}}, x_even[m]};
      assign part[0] = '0;

      // constant multiply as a sum of shifted copies
      for (genvar b = 0; b < MAGW; b++) begin : g_bit
         if (((MAG >> b) & 1) == 1) begin : g_add
            assign part[b+1] = part[b] + (xe <<< b);
         end else begin : g_skip
            assign part[b+1] = part[b];
         end
      end

      if (NEG) begin : g_neg
         assign chain[m+1] = chain[m] - part[MAGW];
      end else begin : g_pos
         assign chain[m+1] = chain[m] + part[MAGW];
      end
   end

   assign ff_sum = chain[FF_ORDER+1];

endmodule

// File: rtl/iirbp_coef_bank.sv
module iirbp_coef_bank #(
   parameter int ORDER  = 8,
   parameter int COEF_W = 32,
   parameter int KW     = $clog2(ORDER)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     we,
   input  logic [KW-1:0]            waddr,
   input  logic signed [COEF_W-1:0] wdata,
   input  logic [KW-1:0]            raddr,
   output logic signed [COEF_W-1:0] rdata
);
   logic signed [COEF_W-1:0] regs [ORDER];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < ORDER; i++) regs[i] <= '0;
      end else if (we && (int'(waddr) < ORDER)) begin
         regs[waddr] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < ORDER; i++) begin
         if (int'(raddr) == i) rdata = regs[i];
      end
   end

endmodule

// File: rtl/iirbp_mac.sv
module iirbp_mac #(
   parameter int COEF_W        = 32,
   parameter int OUT_W         = 32,
   parameter int FRAC_W        = 24,
   parameter int ACC_W         = 44,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     load,
   input  logic signed [ACC_W-1:0]  load_val,
   input  logic                     step,
   input  logic signed [COEF_W-1:0] coef,
   input  logic signed [OUT_W-1:0]  samp,
   output logic signed [ACC_W-1:0]  acc
);
   localparam int PW = COEF_W + OUT_W;
   localparam int RW = PW - FRAC_W;

   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] biased;
   logic signed [ACC_W-1:0] term;
   logic unused_lsbs;

   assign prod = coef * samp;

   if (ROUND_NEAREST) begin : g_round
      localparam logic signed [PW-1:0] HALF =
         {{(PW-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};
      assign biased = prod + HALF;
   end else begin : g_trunc
      assign biased = prod;
   end

   assign term        = {{(ACC_W-RW){biased[PW-1]}}, biased[PW-1:FRAC_W]};
   assign unused_lsbs = ^biased[FRAC_W-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         acc <= '0;
      end else if (load) begin
         acc <= load_val;
      end else if (step) begin
         acc <= acc - term;
      end
   end

endmodule

// File: rtl/iir_bandpass8.sv
module iir_bandpass8 #(
   parameter int IN_W          = 16,
   parameter int OUT_W         = 32,
   parameter int COEF_W        = 32,
   parameter int FRAC_W        = 24,
   parameter int ORDER         = 8,
   parameter int FF_ORDER      = 4,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_valid,
   input  logic signed [IN_W-1:0]   in_sample,
   input  logic                     coef_we,
   input  logic [$clog2(ORDER)-1:0] coef_addr,
   input  logic signed [COEF_W-1:0] coef_data,
   output logic                     out_valid,
   output logic signed [OUT_W-1:0]  y_out
);
   import iirbp_pkg::*;

   localparam int KW    = $clog2(ORDER);
   localparam int XH    = 2 * FF_ORDER;
   localparam int FFW   = IN_W + FF_ORDER + 1;
   localparam int ACC_W = OUT_W + COEF_W - FRAC_W + $clog2(ORDER) + 1;
   localparam logic signed [ACC_W-1:0] SAT_HI =
      {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] SAT_LO =
      {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

   // elaboration-time parameter checks
   if (ORDER < 2) begin : g_bad_order
      $error("ORDER must be at least 2");
   end
   if (FF_ORDER < 1) begin : g_bad_ff
      $error("FF_ORDER must be at least 1");
   end
   if (FRAC_W < 1 || FRAC_W >= COEF_W) begin : g_bad_frac
      $error("FRAC_W must lie in 1..COEF_W-1");
   end
   if (FFW > ACC_W || FFW > OUT_W) begin : g_bad_width
      $error("numerator sum does not fit the accumulator or output");
   end

   seq_state_t             state;
   logic [KW-1:0]          k;
   logic                   busy;
   logic                   accept;
   logic signed [IN_W-1:0] x_cur;
   logic signed [IN_W-1:0] xh [XH];
   logic signed [OUT_W-1:0] yh [ORDER];
   logic signed [IN_W-1:0] x_even [FF_ORDER+1];
   logic signed [FFW-1:0]  ff_sum;
   logic signed [ACC_W-1:0] ff_ext;
   logic signed [ACC_W-1:0] acc;
   logic signed [COEF_W-1:0] coef_rd;
   logic signed [OUT_W-1:0] samp_rd;
   logic signed [OUT_W-1:0] y_sat;
   logic                    unused_sat;

   assign busy   = (state != ST_IDLE);
   assign accept = in_valid && !busy;

   // even-delay inputs only: x[n], x[n-2], ...
   assign x_even[0] = in_sample;
   for (genvar m = 1; m <= FF_ORDER; m++) begin : g_even
      assign x_even[m] = xh[2*m-1];
   end

   iirbp_ff_path #(
      .IN_W(IN_W), .FF_ORDER(FF_ORDER), .FFW(FFW)
   ) u_ff (
      .x_even(x_even),
      .ff_sum(ff_sum)
   );

   assign ff_ext = {{(ACC_W-FFW){ff_sum[FFW-1]}}, ff_sum};

   iirbp_coef_bank #(
      .ORDER(ORDER), .COEF_W(COEF_W), .KW(KW)
   ) u_coef (
      .clk(clk), .rst(rst),
      .we(coef_we), .waddr(coef_addr), .wdata(coef_data),
      .raddr(k), .rdata(coef_rd)
   );

   always_comb begin
      samp_rd = '0;
      for (int i = 0; i < ORDER; i++) begin
         if (int'(k) == i) samp_rd = yh[i];
      end
   end

   iirbp_mac #(
      .COEF_W(COEF_W), .OUT_W(OUT_W), .FRAC_W(FRAC_W),
      .ACC_W(ACC_W), .ROUND_NEAREST(ROUND_NEAREST)
   ) u_mac (
      .clk(clk), .rst(rst),
      .load(accept), .load_val(ff_ext),
      .step(state == ST_MAC),
      .coef(coef_rd), .samp(samp_rd),
      .acc(acc)
   );

   always_comb begin
      if (acc > SAT_HI)      y_sat = SAT_HI[OUT_W-1:0];
      else if (acc < SAT_LO) y_sat = SAT_LO[OUT_W-1:0];
      else                   y_sat = acc[OUT_W-1:0];
   end
   assign unused_sat = ^{SAT_HI[ACC_W-1:OUT_W], SAT_LO[ACC_W-1:OUT_W]};

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= ST_IDLE;
         k         <= '0;
         x_cur     <= '0;
         out_valid <= 1'b0;
         y_out     <= '0;
         for (int i = 0; i < XH; i++)    xh[i] <= '0;
         for (int i = 0; i < ORDER; i++) yh[i] <= '0;
      end else begin
         out_valid <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (in_valid) begin
                  x_cur <= in_sample;
                  k     <= '0;
                  state <= ST_MAC;
               end
            end
            ST_MAC: begin
               k <= k + 1'b1;
               if (k == KW'(ORDER-1)) state <= ST_DONE;
            end
            ST_DONE: begin
               y_out     <= y_sat;
               out_valid <= 1'b1;
               xh[0]     <= x_cur;
               for (int i = 1; i < XH; i++)    xh[i] <= xh[i-1];
               yh[0]     <= y_sat;
               for (int i = 1; i < ORDER; i++) yh[i] <= yh[i-1];
               state     <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/iirbp_checker.sv
module iirbp_checker #(
   parameter int IN_W  = 16,
   parameter int OUT_W = 32,
   parameter int ORDER = 8
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    in_valid,
   input logic                    busy,
   input logic signed [IN_W-1:0]  x_cur,
   input logic                    out_valid,
   input logic signed [OUT_W-1:0] y_out
);
   localparam int CW  = $clog2(ORDER + 4) + 1;
   // counter reads ORDER+2 in the cycle out_valid is high (edges since accept, plus one)
   localparam int LAT = ORDER + 2;

   logic [CW-1:0] lat_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         lat_cnt <= '0;
      end else if (in_valid && !busy) begin
         lat_cnt <= CW'(1);
      end else if (out_valid) begin
         lat_cnt <= '0;
      end else if (lat_cnt != '0) begin
         lat_cnt <= lat_cnt + 1'b1;
      end
   end

   assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (lat_cnt == CW'(LAT)));

   assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);

   assert_busy_ignores_R6: assert property (@(posedge clk) disable iff (rst)
      busy |=> $stable(x_cur));

   assert_output_holds_R7: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> $stable(y_out));

   assert_reset_clears_R8: assert property (@(posedge clk)
      rst |=> (!out_valid && (y_out == '0)));

endmodule

bind iir_bandpass8 iirbp_checker #(
   .IN_W(IN_W), .OUT_W(OUT_W), .ORDER(ORDER)
) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .busy(busy),
   .x_cur(x_cur), .out_valid(out_valid), .y_out(y_out)
);

// File: tb/iir_bandpass8_tb.sv
module iir_bandpass8_tb;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               in_valid = 1'b0;
   logic signed [15:0] in_sample = '0;
   logic               coef_we = 1'b0;
   logic [2:0]         coef_addr = '0;
   logic signed [31:0] coef_data = '0;
   logic               out_valid;
   logic signed [31:0] y_out;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #2 clk = ~clk;   // 250 MHz

   iir_bandpass8 u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
      .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
      .out_valid(out_valid), .y_out(y_out)
   );

   // arithmetic model written from the requirements
   longint mx [8];   // x[n-1] .. x[n-8]
   longint my [8];   // y[n-1] .. y[n-8]
   longint ma [8];   // a_1 .. a_8

   function automatic longint mround(input longint p);
      return (p + 64'sd8388608) >>> 24;   // R3: nearest, ties up
   endfunction

   function automatic longint mstep(input longint x);
      longint s;
      s = x - 4*mx[1] + 6*mx[3] - 4*mx[5] + mx[7];
      for (int i = 0; i < 8; i++) s = s - mround(ma[i] * my[i]);
      if (s > 64'sd2147483647)  s = 64'sd2147483647;
      if (s < -64'sd2147483648) s = -64'sd2147483648;
      for (int i = 7; i > 0; i--) begin
         mx[i] = mx[i-1];
         my[i] = my[i-1];
      end
      mx[0] = x;
      my[0] = s;
      return s;
   endfunction

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < 8; i++) begin
         mx[i] = 0; my[i] = 0; ma[i] = 0;
      end
   endtask

   task automatic wcoef(input int idx, input logic [31:0] val);
      @(negedge clk);
      coef_we = 1'b1; coef_addr = 3'(idx); coef_data = val;
      @(negedge clk);
      coef_we = 1'b0;
      ma[idx] = longint'($signed(val));
   endtask

   // wait for a result after the accepting edge; checks latency and pulse width (R5)
   task automatic wait_out(output longint y);
      int lat;
      lat = 0;
      while (!out_valid && lat < 40) begin
         @(negedge clk);
         lat++;
      end
      y = longint'(y_out);
      chk("R5 latency", lat, 9);
      @(negedge clk);
      chk("R5 single-cycle pulse", longint'(out_valid), 0);
   endtask

   task automatic send(input longint x, output longint y);
      @(negedge clk);
      in_valid = 1'b1; in_sample = 16'(x);
      @(negedge clk);
      in_valid = 1'b0;
      wait_out(y);
   endtask

   // numerator impulse response with zero coefficients
   localparam int NV = 12;
   localparam int STIM [NV] = '{100, 0, 0, 0, 0, 0, 0, 0, 0, 0, 7, -3};
   localparam int EXPV [NV] = '{100, 0, -400, 0, 600, 0, -400, 0, 100, 0, 7, -3};

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         fails++;
         $display("FAIL R5 watchdog: actual %0d cycles expected completion earlier", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      longint y, e, ysave;
      do_reset();
      @(negedge clk);
      chk("R8 out_valid after reset", longint'(out_valid), 0);
      chk("R8 y_out after reset", longint'(y_out), 0);

      // R1: table walk
      for (int i = 0; i < NV; i++) begin
         send(STIM[i], y);
         chk("R1 numerator response", y, EXPV[i]);
      end

      // R2: two feedback taps, a1 = -0.5, a2 = +0.25
      do_reset();
      wcoef(0, 32'hFF80_0000);
      wcoef(1, 32'h0040_0000);
      foreach (STIM[i]) begin
         if (i < 8) begin
            e = mstep(i == 0 ? 1000 : (i == 2 ? -250 : (i == 3 ? 37 : 0)));
            send(i == 0 ? 1000 : (i == 2 ? -250 : (i == 3 ? 37 : 0)), y);
            chk("R2 feedback sum", y, e);
         end
      end

      // R7: output holds between pulses
      ysave = longint'(y_out);
      repeat (6) @(negedge clk);
      chk("R7 y_out held", longint'(y_out), ysave);

      // R3: a1 = +0.5 gives ties; truncation would give -1, -11, 6
      do_reset();
      wcoef(0, 32'h0080_0000);
      send(3, y);  chk("R3 first output", y, 3);
      send(0, y);  chk("R3 tie +1.5 rounds to 2", y, -2);
      send(0, y);  chk("R3 exact -1", y, -11);
      send(0, y);  chk("R3 tie -5.5 rounds to -5", y, 5);

      // R4: a1 = -128.0 drives positive clip
      do_reset();
      wcoef(0, 32'h8000_0000);
      for (int i = 0; i < 6; i++) begin
         e = mstep(i == 0 ? 32767 : 0);
         send(i == 0 ? 32767 : 0, y);
         chk("R4 clipped model", y, e);
      end
      chk("R4 positive limit", y, 64'sd2147483647);

      // R4: negative clip
      do_reset();
      wcoef(0, 32'h8000_0000);
      for (int i = 0; i < 6; i++) begin
         e = mstep(i == 0 ? -32768 : 0);
         send(i == 0 ? -32768 : 0, y);
         chk("R4 clipped model negative", y, e);
      end
      chk("R4 negative limit", y, -64'sd2147483648);

      // R8: reset clears coefficients too: plain numerator response again
      do_reset();
      send(100, y); chk("R8 coef cleared y0", y, 100);
      send(0, y);   chk("R8 coef cleared y1", y, 0);
      send(0, y);   chk("R8 coef cleared y2", y, -400);

      // R6: in_valid held while busy is ignored
      do_reset();
      wcoef(0, 32'hFF80_0000);
      @(negedge clk);
      in_valid = 1'b1; in_sample = 16'sd500;
      @(negedge clk);
      in_sample = 16'sd7777;
      repeat (3) @(negedge clk);
      in_valid = 1'b0;
      e = mstep(500);
      // three negedges already spent after the accepting edge
      begin
         int lat;
         lat = 3;
         while (!out_valid && lat < 40) begin
            @(negedge clk);
            lat++;
         end
         chk("R6 latency unchanged by busy input", lat, 9);
         chk("R6 busy sample ignored", longint'(y_out), e);
      end
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
         e = mstep(0);
         send(0, y);
         chk("R6 history free of ignored sample", y, e);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule